// File: doc/BRIEF.md
# Banked PRG Address Translator

This block sits between a CPU address bus and a cartridge program memory. It turns each CPU address into either a program-ROM address or a work-RAM access. To do this it uses two values that a separate serial loader has already committed: a 5-bit control value and a 5-bit PRG bank value. A single outer-bank bit picks which 256 KB half of a 512 KB image is in use.

The CPU range from 0x8000 up is split into two 16 KB windows. Bits 3:2 of the control value set how the windows are laid out:

- One bank can be pinned to the upper window while the lower window switches.
- Bank 0 can be pinned to the lower window while the upper window switches.
- Both windows can be covered by one 32 KB pair.

The 8 KB range from 0x6000 to 0x7FFF goes to work RAM, gated by the top bit of the bank value. The outputs are registered: they appear one clock after the inputs are sampled.

Top module: `prg_addr_xlat`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it falls, all outputs are 0.
- R2: One clock after the inputs are sampled, `rom_sel` is 1 exactly when `cpu_addr[15]` is 1, and `rom_addr[13:0]` equals `cpu_addr[13:0]`. `rom_addr[18:14]` is the selected 16 KB bank number.
- R3: Mode 3 (`ctrl[3:2]`=11): addresses 0x8000–0xBFFF use bank {outer, `prg[3:0]`}, and 0xC000–0xFFFF use bank {outer, 1111}. With one outer bit this is bank 15 or bank 31.
- R4: Mode 2 (`ctrl[3:2]`=10): 0x8000–0xBFFF use bank {outer, 0000}, and 0xC000–0xFFFF use bank {outer, `prg[3:0]`}.
- R5: Modes 0 and 1 (`ctrl[3:2]`=0x): the bank is {outer, `prg[3:1]`, `cpu_addr[14]`}, so `prg[0]` has no effect.
- R6: `outer_bank` selects which 16-bank half supplies both windows, in every mode.
- R7: The bank number is reduced modulo `NUM_BANKS` (a power of two from 2 to 32). For example, with 8 banks the pinned upper bank is 7.
- R8: The switchable window may hold the same bank as the pinned window, and then both windows give the same ROM addresses.
- R9: `ram_sel` is 1 only for addresses 0x6000–0x7FFF with `prg[4]`=0. When it is 1, `ram_addr` equals `cpu_addr[12:0]`. With `prg[4]`=1 the RAM is never selected.
- R10: When a select output is 0, its address output is 0. Addresses below 0x6000 raise neither select.
- R11: `ctrl[4]`, `ctrl[1]` and `ctrl[0]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| ctrl | input | 5 | Committed control value; bits 3:2 give the window mode |
| prg | input | 5 | Committed bank value; bits 3:0 are the bank, bit 4 disables work RAM |
| outer_bank | input | 1 | Selects the 256 KB half of a 512 KB image |
| rom_sel | output | 1 | ROM access this cycle |
| rom_addr | output | 19 | ROM byte address |
| ram_sel | output | 1 | Work-RAM access this cycle |
| ram_addr | output | 13 | Work-RAM byte address |

## Verification
The assertions take the following for granted:

- `NUM_BANKS` is a power of two.
- All inputs are settled at each rising edge.
- The result for a given edge depends only on the inputs sampled at the previous edge. Properties therefore only look one cycle back, and only when reset was also high on that cycle.

The stimulus respects this. It changes every input only at falling edges, holds each set of inputs over a rising edge, and compares outputs at the next falling edge. A second instance with eight banks exercises the modulo wrap.

// File: rtl/prg_xlat_pkg.sv
// Package: shared types and constants for the PRG address translator.
// Assumes a 16-bit CPU address bus and 16 KB ROM windows.
package prg_xlat_pkg;

    localparam int CPU_AW     = 16;
    localparam int WIN_AW     = 14;
    localparam int RAM_AW     = 13;
    localparam int RAW_BANK_W = 5;
    localparam int MODE_LSB   = 2;

    typedef enum logic [1:0] {
        MODE_PAIR_A  = 2'b00,
        MODE_PAIR_B  = 2'b01,
        MODE_PIN_LOW = 2'b10,
        MODE_PIN_TOP = 2'b11
    } prg_mode_e;

    typedef enum logic [1:0] {
        REGION_NONE,
        REGION_RAM,
        REGION_ROM
    } region_e;

endpackage

// File: rtl/prg_region_decode.sv
// Module: prg_region_decode
// Sorts a CPU address into ROM space (0x8000 and up), the work-RAM
// window (0x6000-0x7FFF) or nothing. Purely combinational.
module prg_region_decode
    import prg_xlat_pkg::*;
(
    input  logic [2:0] addr_top,   // cpu_addr[15:13]
    output region_e    region
);

    // Map the three top address bits to a region
    always_comb begin
        if (addr_top[2]) begin
            region = REGION_ROM;
        end else if (addr_top == 3'b011) begin
            region = REGION_RAM;
        end else begin
            region = REGION_NONE;
        end
    end

endmodule

// File: rtl/prg_bank_select.sv
// Module: prg_bank_select
// Picks the raw 5-bit bank number for a ROM access from the window mode,
// address bit 14, the bank value and the outer-bank bit.
// Assumes the caller only uses the result for ROM-space addresses.
module prg_bank_select
    import prg_xlat_pkg::*;
(
    input  prg_mode_e               mode,
    input  logic                    upper_win,
    input  logic [3:0]              bank_sel,
    input  logic                    outer,
    output logic [RAW_BANK_W-1:0]   raw_bank
);

    // Pinned bank numbers within the selected outer half
    logic [3:0] first_bank;
    logic [3:0] last_bank;

    assign first_bank = 4'h0;
    assign last_bank  = 4'hF;

    // Choose the inner bank for each window per mode
    always_comb begin
        unique case (mode)
            MODE_PAIR_A, MODE_PAIR_B:
                raw_bank = {outer, bank_sel[3:1], upper_win};
            MODE_PIN_LOW:
                raw_bank = upper_win ? {outer, bank_sel} : {outer, first_bank};
            MODE_PIN_TOP:
                raw_bank = upper_win ? {outer, last_bank} : {outer, bank_sel};
            default:
                raw_bank = '0;
        endcase
    end

endmodule

// File: rtl/prg_bank_wrap.sv
// Module: prg_bank_wrap
// Reduces a raw bank number modulo NUM_BANKS. Assumes NUM_BANKS is a
// power of two from 2 to 32; high bits are dropped and zero-filled.
module prg_bank_wrap
    import prg_xlat_pkg::*;
#(
    parameter int NUM_BANKS = 32
) (
    input  logic [RAW_BANK_W-1:0] raw_bank,
    output logic [RAW_BANK_W-1:0] bank
);

    localparam int BANK_W = $clog2(NUM_BANKS);

    generate
        if (BANK_W >= RAW_BANK_W) begin : g_full
            // Image fills every bank number: pass through
            assign bank = raw_bank;
        end else begin : g_masked
            // Smaller image: keep the low bits only
            logic [RAW_BANK_W-BANK_W-1:0] drop_unused;
            assign drop_unused = raw_bank[RAW_BANK_W-1:BANK_W];
            assign bank = {{(RAW_BANK_W-BANK_W){1'b0}}, raw_bank[BANK_W-1:0]};
        end
    endgenerate

endmodule

// File: rtl/prg_addr_xlat.sv
// Module: prg_addr_xlat (top)
// Turns a CPU address into a registered ROM address/select or work-RAM
// address/select, using the committed control and bank values.
// Assumes the control, bank and outer-bank inputs are already committed
// by an external loader and are stable at each rising edge.
module prg_addr_xlat
    import prg_xlat_pkg::*;
#(
    parameter int NUM_BANKS = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [CPU_AW-1:0]                  cpu_addr,
    input  logic [4:0]                         ctrl,
    input  logic [4:0]                         prg,
    input  logic                               outer_bank,
    output logic                               rom_sel,
    output logic [WIN_AW+RAW_BANK_W-1:0]       rom_addr,
    output logic                               ram_sel,
    output logic [RAM_AW-1:0]                  ram_addr
);

    localparam int ROM_AW = WIN_AW + RAW_BANK_W;

    region_e                 region;
    prg_mode_e               mode;
    logic [RAW_BANK_W-1:0]   raw_bank;
    logic [RAW_BANK_W-1:0]   bank;
    logic                    rom_hit;
    logic                    ram_hit;
    logic [ROM_AW-1:0]       rom_addr_d;
    logic [RAM_AW-1:0]       ram_addr_d;
    logic                    ctrl_unused;

    assign mode        = prg_mode_e'(ctrl[MODE_LSB+1:MODE_LSB]);
    assign ctrl_unused = ^{ctrl[4], ctrl[1:0]};

    prg_region_decode u_region (
        .addr_top (cpu_addr[CPU_AW-1:CPU_AW-3]),
        .region   (region)
    );

    prg_bank_select u_select (
        .mode      (mode),
        .upper_win (cpu_addr[WIN_AW]),
        .bank_sel  (prg[3:0]),
        .outer     (outer_bank),
        .raw_bank  (raw_bank)
    );

    prg_bank_wrap #(
        .NUM_BANKS (NUM_BANKS)
    ) u_wrap (
        .raw_bank (raw_bank),
        .bank     (bank)
    );

    // Form next-cycle selects and zero the address of an idle target
    always_comb begin
        rom_hit    = (region == REGION_ROM);
        ram_hit    = (region == REGION_RAM) && !prg[4];
        rom_addr_d = rom_hit ? {bank, cpu_addr[WIN_AW-1:0]} : '0;
        ram_addr_d = ram_hit ? cpu_addr[RAM_AW-1:0] : '0;
    end

    // Register all outputs; synchronous active-low reset clears them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_sel  <= 1'b0;
            rom_addr <= '0;
            ram_sel  <= 1'b0;
            ram_addr <= '0;
        end else begin
            rom_sel  <= rom_hit;
            rom_addr <= rom_addr_d;
            ram_sel  <= ram_hit;
            ram_addr <= ram_addr_d;
        end
    end

endmodule

// File: rtl/prg_addr_xlat_chk.sv
// Module: prg_addr_xlat_chk
// Checker bound to prg_addr_xlat. It relates the registered outputs to
// the inputs sampled one edge earlier, only when reset was high then.
module prg_addr_xlat_chk #(
    parameter int NUM_BANKS = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [4:0]  ctrl,
    input logic [4:0]  prg,
    input logic        outer_bank,
    input logic        rom_sel,
    input logic [18:0] rom_addr,
    input logic        ram_sel,
    input logic [12:0] ram_addr
);

    localparam logic [4:0] BANK_MASK = 5'(NUM_BANKS - 1);

    logic chk_unused;
    assign chk_unused = ^{ctrl[4], ctrl[1:0], ram_addr};

    AST_SELECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel)); // R10

    AST_ROM_SEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rom_sel == $past(cpu_addr[15]))); // R2

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rom_sel) |-> (rom_addr[13:0] == $past(cpu_addr[13:0]))); // R2

    AST_PIN_TOP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_addr[15:14] == 2'b11 && ctrl[3:2] == 2'b11))
        |-> (rom_addr[18:14] == ({$past(outer_bank), 4'hF} & BANK_MASK))); // R3

    AST_PIN_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_addr[15:14] == 2'b10 && ctrl[3:2] == 2'b10))
        |-> (rom_addr[18:14] == ({$past(outer_bank), 4'h0} & BANK_MASK))); // R4

    AST_RAM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ram_sel == $past(cpu_addr[15:13] == 3'b011 && !prg[4]))); // R9

    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[18:14] <= BANK_MASK); // R7

    AST_IDLE_ROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel |-> (rom_addr == '0)); // R10

endmodule

bind prg_addr_xlat prg_addr_xlat_chk #(
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .ctrl       (ctrl),
    .prg        (prg),
    .outer_bank (outer_bank),
    .rom_sel    (rom_sel),
    .rom_addr   (rom_addr),
    .ram_sel    (ram_sel),
    .ram_addr   (ram_addr)
);

// File: tb/tb_prg_addr_xlat.sv
// Bench for prg_addr_xlat: vector table walk, then directed reset and
// wrap checks on a second, 8-bank instance.
module tb_prg_addr_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [4:0]  ctrl = '0;
    logic [4:0]  prg = '0;
    logic        outer_bank = 1'b0;
    logic        rom_sel, ram_sel, rom_sel8, ram_sel8;
    logic [18:0] rom_addr, rom_addr8;
    logic [12:0] ram_addr, ram_addr8;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    prg_addr_xlat #(.NUM_BANKS(32)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ctrl(ctrl), .prg(prg),
        .outer_bank(outer_bank), .rom_sel(rom_sel), .rom_addr(rom_addr),
        .ram_sel(ram_sel), .ram_addr(ram_addr)
    );

    prg_addr_xlat #(.NUM_BANKS(8)) dut8 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ctrl(ctrl), .prg(prg),
        .outer_bank(outer_bank), .rom_sel(rom_sel8), .rom_addr(rom_addr8),
        .ram_sel(ram_sel8), .ram_addr(ram_addr8)
    );

    typedef struct packed {
        logic [23:0] req;
        logic [15:0] addr;
        logic [4:0]  ctrl;
        logic [4:0]  prg;
        logic        outer;
        logic        rsel;
        logic [18:0] raddr;
        logic        msel;
        logic [12:0] maddr;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{"R3", 16'h8000, 5'h0C, 5'h05, 1'b0, 1'b1, 19'h14000, 1'b0, 13'h0000},
        '{"R3", 16'hC123, 5'h0C, 5'h05, 1'b0, 1'b1, 19'h3C123, 1'b0, 13'h0000},
        '{"R6", 16'hFFFF, 5'h0C, 5'h05, 1'b1, 1'b1, 19'h7FFFF, 1'b0, 13'h0000},
        '{"R6", 16'h8010, 5'h0C, 5'h03, 1'b1, 1'b1, 19'h4C010, 1'b0, 13'h0000},
        '{"R4", 16'h9000, 5'h08, 5'h06, 1'b0, 1'b1, 19'h01000, 1'b0, 13'h0000},
        '{"R4", 16'hD000, 5'h08, 5'h06, 1'b0, 1'b1, 19'h19000, 1'b0, 13'h0000},
        '{"R6", 16'hA000, 5'h08, 5'h06, 1'b1, 1'b1, 19'h42000, 1'b0, 13'h0000},
        '{"R5", 16'h8004, 5'h00, 5'h05, 1'b0, 1'b1, 19'h10004, 1'b0, 13'h0000},
        '{"R5", 16'h8004, 5'h00, 5'h04, 1'b0, 1'b1, 19'h10004, 1'b0, 13'h0000},
        '{"R5", 16'hC004, 5'h00, 5'h05, 1'b0, 1'b1, 19'h14004, 1'b0, 13'h0000},
        '{"R5", 16'hC004, 5'h04, 5'h04, 1'b0, 1'b1, 19'h14004, 1'b0, 13'h0000},
        '{"R8", 16'h8000, 5'h0C, 5'h0F, 1'b0, 1'b1, 19'h3C000, 1'b0, 13'h0000},
        '{"R8", 16'hC000, 5'h0C, 5'h0F, 1'b0, 1'b1, 19'h3C000, 1'b0, 13'h0000},
        '{"R9", 16'h6000, 5'h0C, 5'h05, 1'b0, 1'b0, 19'h00000, 1'b1, 13'h0000},
        '{"R9", 16'h7FFF, 5'h0C, 5'h05, 1'b0, 1'b0, 19'h00000, 1'b1, 13'h1FFF},
        '{"R9", 16'h7FFF, 5'h0C, 5'h15, 1'b0, 1'b0, 19'h00000, 1'b0, 13'h0000},
        '{"R10", 16'h5FFF, 5'h0C, 5'h05, 1'b0, 1'b0, 19'h00000, 1'b0, 13'h0000},
        '{"R10", 16'h0000, 5'h00, 5'h00, 1'b1, 1'b0, 19'h00000, 1'b0, 13'h0000},
        '{"R11", 16'hC000, 5'h1F, 5'h02, 1'b0, 1'b1, 19'h3C000, 1'b0, 13'h0000}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [4:0] c,
                         input logic [4:0] p, input logic o);
        @(negedge clk);
        cpu_addr   = a;
        ctrl       = c;
        prg        = p;
        outer_bank = o;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs held at zero while reset is low, even with a ROM address driven
        cpu_addr = 16'hC000; ctrl = 5'h0C; prg = 5'h05;
        repeat (3) @(negedge clk);
        check("R1", "rom_sel in reset", 32'(rom_sel), 32'd0);
        check("R1", "rom_addr in reset", 32'(rom_addr), 32'd0);
        check("R1", "ram_sel in reset", 32'(ram_sel), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 covered by every rom_addr offset comparison
        for (int i = 0; i < NV; i++) begin
            string r;
            r = string'(VECS[i].req);
            drive(VECS[i].addr, VECS[i].ctrl, VECS[i].prg, VECS[i].outer);
            check(r, "rom_sel (R2)", 32'(rom_sel), 32'(VECS[i].rsel));
            check(r, "rom_addr (R2)", 32'(rom_addr), 32'(VECS[i].raddr));
            check(r, "ram_sel", 32'(ram_sel), 32'(VECS[i].msel));
            check(r, "ram_addr", 32'(ram_addr), 32'(VECS[i].maddr));
        end

        // R7: 8-bank image wraps bank numbers, pinned top becomes bank 7
        drive(16'h8000, 5'h0C, 5'h0D, 1'b1);
        check("R7", "8-bank switch window", 32'(rom_addr8), 32'h14000);
        drive(16'hC000, 5'h0C, 5'h0D, 1'b1);
        check("R7", "8-bank pinned top", 32'(rom_addr8), 32'h1C000);
        drive(16'h9234, 5'h08, 5'h03, 1'b0);
        check("R7", "8-bank pinned low", 32'(rom_addr8), 32'h01234);

        // R1: reset asserted mid-run clears outputs on the next edge
        drive(16'hFFFF, 5'h0C, 5'h05, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "rom_sel after reset", 32'(rom_sel), 32'd0);
        check("R1", "rom_addr after reset", 32'(rom_addr), 32'd0);
        rst_n = 1'b1;
        drive(16'h7000, 5'h0C, 5'h00, 1'b0);
        check("R9", "ram after reset release", 32'(ram_addr), 32'h1000);

        finish_run();
    end

endmodule